// File: doc/BRIEF.md
# Presettable Counter Bank Latch

This block turns a small synchronous counter into the bank-select register of a cartridge on an 8-bit CPU bus. The counter has an asynchronous active-low clear, an active-low parallel load, two count enables that must both be high for it to advance, and a carry output. The CPU side brings the top address bit, the phase-2 bus strobe, the read/write line (high for read, low for write) and a slice of the data bus. A select strobe is formed from the top address bit and phase-2. At the rising edge of that strobe, the read/write line acts as the counter's load input. A CPU write to the upper half of the address space therefore latches the data slice into the counter. The counter's outputs drive the upper program-memory address lines.

The block also produces an active-low program-ROM output enable. It is asserted only while the select strobe is active and the CPU is reading, so the ROM never drives the data bus against a CPU write. In plain latch use the clear is held inactive and both count enables are held low, so the register changes only by loading. The enables stay available as pins so that the counter behaviour can be used too.

Everything runs on one system clock. The select strobe is followed by a two-state machine. In `STB_LOW` the strobe is inactive. On the `STB_LOW -> STB_HIGH` transition it issues a one-cycle capture pulse. It returns through `STB_HIGH -> STB_LOW` once the strobe drops. The counter acts only on that pulse, so the bank lines change only at the clock edge that first samples the strobe high.

Top module: `bank_latch_mapper`

## Requirements
- R1: While `clr_n` is low, `bank` is 0 at once, without waiting for a clock edge.
- R2: A write (`rw`=0) whose select strobe (`addr_hi`=1 and `phi2`=1) is first sampled high at a rising clock edge sets `bank` to `cpu_data` at that edge.
- R3: A read (`rw`=1) with the select strobe active and `cnt_en`=0 leaves `bank` unchanged.
- R4: A write with `addr_hi`=0 leaves `bank` unchanged, even while `phi2` pulses.
- R5: Each activation of the select strobe causes at most one capture: changing `cpu_data` while the strobe stays high does not change `bank` again.
- R6: At a strobe activation with `rw`=1, `cnt_en`=1 and `carry_in`=1, `bank` increases by one, and it wraps from 15 to 0.
- R7: If only one of `cnt_en` and `carry_in` is high, a read strobe does not change `bank`.
- R8: `carry_out` is 1 exactly when `carry_in`=1 and `bank`=15, whatever the value of `cnt_en`.
- R9: Load takes priority over counting: a write strobe with both count enables high loads `cpu_data`.
- R10: `rom_oe_n` is 0 only while the select strobe is active and `rw`=1. It is 1 during writes and whenever the strobe is inactive.
- R11: Clear takes priority over load: a write strobe while `clr_n` is low leaves `bank` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr_n | input | 1 | Asynchronous active-low clear of the counter and the strobe tracker |
| addr_hi | input | 1 | Top CPU address bit |
| phi2 | input | 1 | CPU phase-2 strobe, high while the bus is stable |
| rw | input | 1 | CPU read/write, 1 = read, 0 = write (acts as the active-low load) |
| cpu_data | input | WIDTH | Data bus slice that is latched |
| cnt_en | input | 1 | Count enable, tied low in latch use |
| carry_in | input | 1 | Carry input / second count enable, tied low in latch use |
| bank | output | WIDTH | Upper program-memory address lines |
| carry_out | output | 1 | High when `carry_in` is high and `bank` is at its maximum |
| rom_oe_n | output | 1 | Active-low program-ROM output enable |

## Verification
The bench uses the default `WIDTH` of 4. At that width a counting run needs only a few strobes to reach 15, see `carry_out` there, and step over the wrap to 0. At the same width every load value fits in a few hex literals, so clear, load and count priorities can each be set against a distinct bank value. The short strobe cycles also leave room to hold the strobe high for several clocks and show that it causes a single capture.

// File: rtl/bank_latch_pkg.sv
package bank_latch_pkg;
    typedef enum logic {
        STB_LOW  = 1'b0,
        STB_HIGH = 1'b1
    } stb_state_t;
endpackage

// File: rtl/bl_strobe_fsm.sv
module bl_strobe_fsm
    import bank_latch_pkg::*;
(
    input  logic clk,
    input  logic clr_n,
    input  logic addr_hi,
    input  logic phi2,
    output logic sel,
    output logic tick
);
    stb_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) state_q <= STB_LOW;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        sel     = addr_hi & phi2;
        state_d = state_q;
        tick    = 1'b0;
        unique case (state_q)
            STB_LOW: begin
                if (sel) begin
                    state_d = STB_HIGH;
                    tick    = 1'b1;
                end
            end
            STB_HIGH: begin
                if (!sel) state_d = STB_LOW;
            end
            default: state_d = STB_LOW;
        endcase
    end

    // R5: one capture pulse per strobe activation
    a_r5_single_tick: assert property (@(posedge clk) disable iff (!clr_n)
        tick |=> !tick);

    // R4: no capture without the top address bit
    a_r4_no_tick_low: assert property (@(posedge clk) disable iff (!clr_n)
        !addr_hi |-> !tick);
endmodule

// File: rtl/bl_preset_counter.sv
module bl_preset_counter #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             tick,
    input  logic             load_n,
    input  logic             cnt_en,
    input  logic             carry_in,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic             carry_out
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    logic advance;
    assign advance = cnt_en & carry_in;

    // clear > load > count
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q <= '0;
        end else if (tick) begin
            if (!load_n)      q <= d;
            else if (advance) q <= q + 1'b1;
        end
    end

    assign carry_out = carry_in & (q == TOP);

    // R2 / R9: load wins over counting
    a_r2_load: assert property (@(posedge clk) disable iff (!clr_n)
        (tick && !load_n) |=> (q == $past(d)));

    // R6: increment with wrap
    a_r6_count: assert property (@(posedge clk) disable iff (!clr_n)
        (tick && load_n && cnt_en && carry_in) |=> (q == WIDTH'($past(q) + 1'b1)));

    // R3 / R7: hold unless loading or both enables are set
    a_r7_hold: assert property (@(posedge clk) disable iff (!clr_n)
        (!tick || (load_n && !(cnt_en && carry_in))) |=> $stable(q));

    // R8: carry out announces the wrap
    a_r8_carry_wrap: assert property (@(posedge clk) disable iff (!clr_n)
        (carry_out && tick && load_n && cnt_en) |=> (q == '0));
endmodule

// File: rtl/bl_rom_gate.sv
module bl_rom_gate (
    input  logic clk,
    input  logic clr_n,
    input  logic sel,
    input  logic rw,
    output logic rom_oe_n
);
    assign rom_oe_n = ~(sel & rw);

    // R10: ROM never enabled during a write or when not selected
    a_r10_no_conflict: assert property (@(posedge clk) disable iff (!clr_n)
        (!rw || !sel) |-> rom_oe_n);
endmodule

// File: rtl/bank_latch_mapper.sv
module bank_latch_mapper #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             addr_hi,
    input  logic             phi2,
    input  logic             rw,
    input  logic [WIDTH-1:0] cpu_data,
    input  logic             cnt_en,
    input  logic             carry_in,
    output logic [WIDTH-1:0] bank,
    output logic             carry_out,
    output logic             rom_oe_n
);
    logic sel;
    logic tick;

    bl_strobe_fsm u_strobe (
        .clk     (clk),
        .clr_n   (clr_n),
        .addr_hi (addr_hi),
        .phi2    (phi2),
        .sel     (sel),
        .tick    (tick)
    );

    bl_preset_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk       (clk),
        .clr_n     (clr_n),
        .tick      (tick),
        .load_n    (rw),
        .cnt_en    (cnt_en),
        .carry_in  (carry_in),
        .d         (cpu_data),
        .q         (bank),
        .carry_out (carry_out)
    );

    bl_rom_gate u_gate (
        .clk      (clk),
        .clr_n    (clr_n),
        .sel      (sel),
        .rw       (rw),
        .rom_oe_n (rom_oe_n)
    );

    // R3: a read strobe with counting off keeps the bank
    a_r3_read_hold: assert property (@(posedge clk) disable iff (!clr_n)
        (rw && !cnt_en) |=> $stable(bank));
endmodule

// File: tb/bank_latch_mapper_tb.sv
module bank_latch_mapper_tb;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         clr_n;
    logic         addr_hi, phi2, rw, cnt_en, carry_in;
    logic [W-1:0] cpu_data;
    logic [W-1:0] bank;
    logic         carry_out, rom_oe_n;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    bank_latch_mapper #(.WIDTH(W)) u_dut (
        .clk(clk), .clr_n(clr_n), .addr_hi(addr_hi), .phi2(phi2), .rw(rw),
        .cpu_data(cpu_data), .cnt_en(cnt_en), .carry_in(carry_in),
        .bank(bank), .carry_out(carry_out), .rom_oe_n(rom_oe_n)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one strobe cycle; checks rom enable mid-strobe, leaves strobe low afterwards
    task automatic bus_cycle(input logic ahi, input logic r, input logic [W-1:0] d,
                             input logic ce, input logic ci, input int exp_oe);
        @(negedge clk);
        addr_hi = ahi; rw = r; cpu_data = d; cnt_en = ce; carry_in = ci; phi2 = 1'b1;
        #1 check("R10 rom_oe_n during strobe", int'(rom_oe_n), exp_oe);
        @(posedge clk);
        @(negedge clk);
        phi2 = 1'b0; addr_hi = 1'b0; rw = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 bank after clear", int'(bank), 0);
        check("R10 rom_oe_n idle", int'(rom_oe_n), 1);
        check("R8 carry_out idle", int'(carry_out), 0);
    endtask

    task automatic t_write_load();
        bus_cycle(1'b1, 1'b0, 4'hA, 1'b0, 1'b0, 1);
        check("R2 write loads bank", int'(bank), 10);
    endtask

    task automatic t_read_ignored();
        bus_cycle(1'b1, 1'b1, 4'h5, 1'b0, 1'b0, 0);
        check("R3 read keeps bank", int'(bank), 10);
    endtask

    task automatic t_low_write();
        bus_cycle(1'b0, 1'b0, 4'h3, 1'b0, 1'b0, 1);
        check("R4 low write ignored", int'(bank), 10);
    endtask

    task automatic t_single_capture();
        @(negedge clk);
        addr_hi = 1'b1; rw = 1'b0; cpu_data = 4'h6; phi2 = 1'b1;
        @(negedge clk);
        check("R5 first capture", int'(bank), 6);
        for (int i = 0; i < 3; i++) begin
            cpu_data = 4'h9;
            @(negedge clk);
        end
        check("R5 no second capture", int'(bank), 6);
        phi2 = 1'b0; addr_hi = 1'b0; rw = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_count();
        bus_cycle(1'b1, 1'b0, 4'hD, 1'b0, 1'b0, 1);
        check("R2 preload 13", int'(bank), 13);
        bus_cycle(1'b1, 1'b1, 4'h0, 1'b1, 1'b1, 0);
        check("R6 count to 14", int'(bank), 14);
        bus_cycle(1'b1, 1'b1, 4'h0, 1'b1, 1'b1, 0);
        check("R6 count to 15", int'(bank), 15);
        cnt_en = 1'b0; carry_in = 1'b1; #1;
        check("R8 carry at 15 without cnt_en", int'(carry_out), 1);
        carry_in = 1'b0; #1;
        check("R8 no carry without carry_in", int'(carry_out), 0);
        bus_cycle(1'b1, 1'b1, 4'h0, 1'b1, 1'b1, 0);
        check("R6 wrap to 0", int'(bank), 0);
        check("R8 no carry at 0", int'(carry_out), 0);
    endtask

    task automatic t_partial_enable();
        bus_cycle(1'b1, 1'b1, 4'h0, 1'b1, 1'b0, 0);
        check("R7 cnt_en only", int'(bank), 0);
        bus_cycle(1'b1, 1'b1, 4'h0, 1'b0, 1'b1, 0);
        check("R7 carry_in only", int'(bank), 0);
    endtask

    task automatic t_load_priority();
        bus_cycle(1'b1, 1'b0, 4'h2, 1'b1, 1'b1, 1);
        check("R9 load over count", int'(bank), 2);
        cnt_en = 1'b0; carry_in = 1'b0;
    endtask

    task automatic t_clear();
        @(negedge clk);
        #1 clr_n = 1'b0;
        #0.5 check("R1 async clear", int'(bank), 0);
        bus_cycle(1'b1, 1'b0, 4'h7, 1'b0, 1'b0, 1);
        check("R11 clear over load", int'(bank), 0);
        clr_n = 1'b1;
        bus_cycle(1'b1, 1'b0, 4'h4, 1'b0, 1'b0, 1);
        check("R2 load after clear", int'(bank), 4);
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        clr_n = 1'b0; addr_hi = 1'b0; phi2 = 1'b0; rw = 1'b1;
        cpu_data = '0; cnt_en = 1'b0; carry_in = 1'b0;
        repeat (3) @(negedge clk);
        clr_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_load();
        t_read_ignored();
        t_low_write();
        t_single_capture();
        t_count();
        t_partial_enable();
        t_load_priority();
        t_clear();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule